// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM burst, one per clock, from the single column presented with a read or write command. After the start pulse, no further column input is needed. The block works out every later address itself, using the selected burst length and ordering.

The burst length is 1, 2, 4 or 8 beats. It confines the burst to an aligned block of that size. Only the low log2(length) bits of the column change, and all higher bits keep the starting value.

Sequential ordering counts upward from the start and wraps inside the aligned block. Interleave ordering XORs the beat number into the low bits.

A terminate input cuts a burst short. An active-low clock-enable freezes the generator for as long as it is low.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `col_vld` and `col_last` are 0.
- R2: A `start` sampled high at an enabled edge makes `col_vld` 1 after that edge, with `col_out` equal to `start_col` (beat 0).
- R3: `blen_sel` encodes the burst length as 2^`blen_sel` (0→1, 1→2, 2→4, 3→8), and an uninterrupted burst shows exactly that many valid beats on consecutive enabled cycles.
- R4: With `ileave` = 0 (sequential), beat k has low log2(BL) bits equal to (start low bits + k) mod BL.
- R5: With `ileave` = 1 (interleave), beat k has low log2(BL) bits equal to start low bits XOR k.
- R6: Column bits above the low log2(BL) bits equal those of `start_col` on every beat of the burst.
- R7: `col_last` is 1 on the final beat (beat BL-1) of a burst and on no other beat. If no new start arrives, `col_vld` is 0 on the following cycle.
- R8: A `start` sampled while a burst is on its last beat, or on any other beat, begins the new burst on the very next cycle with no idle gap.
- R9: A `stop` sampled high at an enabled edge without `start` makes `col_vld` 0 after that edge. When `start` and `stop` are both high, `start` wins.
- R10: While `hold_n` is 0, edges are ignored. `col_out`, `col_vld` and `col_last` stay unchanged, and `start` and `stop` have no effect. The burst resumes from the held beat once `hold_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_n | input | 1 | Clock enable; 0 freezes the generator |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | Column of the first beat |
| blen_sel | input | 2 | Burst length select, length = 2^value |
| ileave | input | 1 | 0 sequential ordering, 1 interleave ordering |
| stop | input | 1 | Terminate the current burst |
| col_out | output | 9 | Column address of the current beat |
| col_vld | output | 1 | `col_out` holds a beat of a burst |
| col_last | output | 1 | Current beat is the final one |

## Verification
A corrupted beat counter shows up directly on the low bits of `col_out`, in the very next beat. It also moves `col_last` to the wrong cycle, which then lengthens or shortens the valid window. A wrong stored length mask or ordering flag appears one cycle after the start, either on the second beat's address or as a change in the upper bits. A scoreboard compares every beat against addresses computed from the ordering formulas. Any surplus or missing beat is therefore caught at the cycle it occurs.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [SEL_W-1:0] blen_sel,
  input  logic             ileave,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_vld,
  output logic             col_last
);
  localparam int OFS_W = (1 << SEL_W) - 1;

  logic [COL_W-1:0] base_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] mask_q;
  logic             ilv_q;
  logic             vld_q;

  logic [OFS_W-1:0] len_mask;
  logic [OFS_W-1:0] base_lo;
  logic [OFS_W-1:0] seq_lo;
  logic [OFS_W-1:0] ilv_lo;
  logic [OFS_W-1:0] pick_lo;

  assign len_mask = OFS_W'((1 << blen_sel) - 1);
  assign base_lo  = base_q[OFS_W-1:0];
  assign seq_lo   = base_lo + beat_q;
  assign ilv_lo   = base_lo ^ beat_q;
  assign pick_lo  = ilv_q ? ilv_lo : seq_lo;

  assign col_out  = {base_q[COL_W-1:OFS_W], (base_lo & ~mask_q) | (pick_lo & mask_q)};
  assign col_vld  = vld_q;
  assign col_last = vld_q && (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else if (hold_n) begin
      if (start) begin
        base_q <= start_col;
        beat_q <= '0;
        mask_q <= len_mask;
        ilv_q  <= ileave;
        vld_q  <= 1'b1;
      end else if (stop || col_last) begin
        vld_q  <= 1'b0;
      end else if (vld_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hold_n) |=> (col_vld && col_out == $past(start_col)));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && !col_last && hold_n && !start && !stop)
      |=> (col_vld && col_out[COL_W-1:OFS_W] == $past(col_out[COL_W-1:OFS_W])));

  // R7
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && hold_n && !start) |=> !col_vld);

  // R9
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && hold_n && !start) |=> !col_vld);

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> ($stable(col_out) && $stable(col_vld) && $stable(col_last)));
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_n = 1'b1;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [1:0] blen_sel = '0;
  logic       ileave = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] col_out;
  logic       col_vld;
  logic       col_last;

  typedef struct {
    logic [8:0] col;
    logic       last;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   prev_en = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .start(start),
    .start_col(start_col), .blen_sel(blen_sel), .ileave(ileave), .stop(stop),
    .col_out(col_out), .col_vld(col_vld), .col_last(col_last)
  );

  always @(posedge clk) prev_en <= hold_n;

  function automatic logic [8:0] beat_col(logic [8:0] c, int bl, bit ilv, int k);
    logic [8:0] m;
    logic [8:0] lo;
    m  = 9'(bl - 1);
    lo = ilv ? (c ^ 9'(k)) : (c + 9'(k));
    return (c & ~m) | (lo & m);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && col_vld && prev_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected beat", int'(col_out), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(col_out == e.col, e.req, "col_out", int'(col_out), int'(e.col));
        check(col_last == e.last, e.req, "col_last", int'(col_last), int'(e.last));
      end
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_burst(logic [8:0] c, int sel, bit ilv, int npush, bit with_stop, string req);
    int bl;
    bl = 1 << sel;
    start     = 1'b1;
    stop      = with_stop;
    start_col = c;
    blen_sel  = 2'(sel);
    ileave    = ilv;
    for (int k = 0; k < npush; k++) begin
      exp_t e;
      e.col  = beat_col(c, bl, ilv, k);
      e.last = (k == bl - 1);
      e.req  = req;
      exp_q.push_back(e);
    end
    @(negedge clk);
    start     = 1'b0;
    stop      = 1'b0;
    start_col = 9'h155;
  endtask

  task automatic check_idle(string req);
    check(col_vld == 1'b0, req, "col_vld idle", int'(col_vld), 0);
    check(col_last == 1'b0, req, "col_last idle", int'(col_last), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    wait_n(3);
    // R1
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // R2 R3: length 1
    run_burst(9'h0AB, 0, 1'b0, 1, 1'b0, "R2");
    wait_n(1); check_idle("R3");
    // R4: length 2 sequential with wrap
    run_burst(9'h0FF, 1, 1'b0, 2, 1'b0, "R4");
    wait_n(2); check_idle("R3");
    // R4 R6: length 8 sequential
    run_burst(9'h123, 3, 1'b0, 8, 1'b0, "R4");
    wait_n(8); check_idle("R7");
    // R5: length 8 interleave
    run_burst(9'h0A5, 3, 1'b1, 8, 1'b0, "R5");
    wait_n(8); check_idle("R7");
    // R5 R6: length 4 interleave
    run_burst(9'h1F2, 2, 1'b1, 4, 1'b0, "R6");
    wait_n(4); check_idle("R3");

    // R8: back-to-back bursts
    run_burst(9'h011, 1, 1'b1, 2, 1'b0, "R8");
    wait_n(1);
    run_burst(9'h100, 2, 1'b0, 4, 1'b0, "R8");
    wait_n(3);
    run_burst(9'h1FF, 0, 1'b0, 1, 1'b0, "R8");
    run_burst(9'h000, 0, 1'b1, 1, 1'b0, "R8");
    wait_n(1); check_idle("R8");
    // R8: restart mid-burst
    run_burst(9'h0C6, 3, 1'b0, 2, 1'b0, "R8");
    wait_n(1);
    run_burst(9'h037, 2, 1'b1, 4, 1'b0, "R8");
    wait_n(4); check_idle("R8");

    // R9: terminate after three beats
    run_burst(9'h1A0, 3, 1'b0, 3, 1'b0, "R9");
    wait_n(2);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check_idle("R9");
    wait_n(2); check_idle("R9");
    // R9: start beats stop
    run_burst(9'h05A, 1, 1'b0, 2, 1'b1, "R9");
    wait_n(2); check_idle("R9");

    // R10: hold with start and stop ignored
    run_burst(9'h1F5, 2, 1'b0, 4, 1'b0, "R10");
    hold_n    = 1'b0;
    start     = 1'b1;
    stop      = 1'b1;
    start_col = 9'h022;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(col_out == 9'h1F5, "R10", "held col_out", int'(col_out), 'h1F5);
      check(col_vld == 1'b1, "R10", "held col_vld", int'(col_vld), 1);
    end
    start  = 1'b0;
    stop   = 1'b0;
    hold_n = 1'b1;
    wait_n(4); check_idle("R10");
    check(exp_q.size() == 0, "R3", "beats left in queue", exp_q.size(), 0);
    wait_n(2);
    finish_run();
  end
endmodule